// File: doc/BRIEF.md
# Marker-Bearing Byte Encoder

This block turns each 8-bit byte into a 10-bit codeword. Every codeword carries the fixed marker nibble `0101`. The marker sits at a position chosen by the byte's leading bits, and the remaining byte bits are arranged around it with small permutations. A receiver can therefore locate the field boundaries from the marker alone. Over all 256 bytes the mapping is one-to-one, and it never produces a word in the reserved band 336..351.

Encoding has one register stage. A byte presented with its valid strobe appears as a codeword with a valid flag one cycle later. The block also contains a purely combinational decoder that inverts the mapping. It flags any 10-bit word that no byte produces, so round trips can be checked and stray words rejected.

Bit numbering in the requirements is big-endian: byte position 0 is `in_byte[7]` and position 7 is `in_byte[0]`; codeword position 0 is `out_code[9]` and position 9 is `out_code[0]`. Below, `b` denotes byte positions and the listed codeword bits run from position 0 to position 9.

Top module: `marker_enc10`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, `out_valid` and `out_code` become 0 at that edge.
- R2: A byte taken with `in_valid` high at a rising edge appears on `out_code` with `out_valid` high right after that edge, which is one cycle of latency.
- R3: At an edge where `in_valid` is low, `out_valid` falls to 0 and `out_code` keeps its previous value whatever `in_byte` carries.
- R4: When b[0:1]=00 and b[2:3]=01, the codeword is 1,b5,b4,b6,0,0,1,0,1,b7. For any other byte with b[0:1]=00, it is 0,1,0,1 followed by b2..b7.
- R5: When b[0:1]=01, the codeword is b2,0,1,0,1,b3,b4,b5,b6,b7.
- R6: When b[0:1]=10 and b[2:3]=01, the codeword is b4,b5,0,0,b6,b7,0,1,0,1. For any other byte with b[0:1]=10, it is b2,b3,0,1,0,1,b4,b5,b6,b7.
- R7: When b[0:1]=11 and b[3:4]=01, the codeword is b2,b5,1,1,b6,b7,0,1,0,1. For any other byte with b[0:1]=11, it is b2,b3,b4,0,1,0,1,b5,b6,b7.
- R8: No two bytes give the same codeword, and no codeword lies in 336..351.
- R9: For every codeword the encoder can produce, `dec_byte` equals the byte that produced it and `dec_err` is 0, combinationally.
- R10: For every 10-bit word that no byte produces, including 336..351, `dec_err` is 1 and `dec_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Byte to encode |
| out_valid | output | 1 | Codeword valid, registered |
| out_code | output | 10 | Registered codeword |
| dec_code | input | 10 | Word to decode |
| dec_byte | output | 8 | Decoded byte |
| dec_err | output | 1 | Word is not a legal codeword |

## Verification
The encoded result is due one rising edge after the strobe. The bench drives each byte at a falling edge and reads `out_code` and `out_valid` at the next falling edge, after exactly one rising edge. The hold and reset checks also sample one falling edge after the edge under test. The decoder has no register, so the bench sets `dec_code` and reads `dec_byte` and `dec_err` a short delay later within the same cycle, sweeping all 1024 words.

// File: rtl/marker_enc10.sv
module marker_enc10 (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [9:0] out_code,
  input  logic [9:0] dec_code,
  output logic [7:0] dec_byte,
  output logic       dec_err
);

  function automatic logic [9:0] enc(input logic [7:0] x);
    logic [0:7] b;
    logic [0:9] o;
    b = x;
    case (b[0:1])
      2'b00: o = (b[2:3] == 2'b01) ? {1'b1, b[5], b[4], b[6], 5'b00101, b[7]}
                                   : {4'b0101, b[2:7]};
      2'b01: o = {b[2], 4'b0101, b[3:7]};
      2'b10: o = (b[2:3] == 2'b01) ? {b[4:5], 2'b00, b[6:7], 4'b0101}
                                   : {b[2:3], 4'b0101, b[4:7]};
      default: o = (b[3:4] == 2'b01) ? {b[2], b[5], 2'b11, b[6:7], 4'b0101}
                                     : {b[2:4], 4'b0101, b[5:7]};
    endcase
    return o;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= enc(in_byte);
    end
  end

  logic [0:9] w;
  logic [7:0] cand [7];
  assign w = dec_code;

  always_comb begin
    cand[0] = {4'b0001, w[2], w[1], w[3], w[9]};
    cand[1] = {2'b00, w[4:9]};
    cand[2] = {2'b01, w[0], w[5:9]};
    cand[3] = {4'b1001, w[0:1], w[4:5]};
    cand[4] = {2'b10, w[0:1], w[6:9]};
    cand[5] = {2'b11, w[0], 2'b01, w[1], w[4:5]};
    cand[6] = {2'b11, w[0:2], w[7:9]};
  end

  always_comb begin
    dec_byte = '0;
    dec_err  = 1'b1;
    for (int i = 0; i < 7; i++) begin
      if (dec_err && enc(cand[i]) == dec_code) begin
        dec_byte = cand[i];
        dec_err  = 1'b0;
      end
    end
  end

endmodule

module marker_enc10_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [9:0] out_code,
  input logic [9:0] dec_code,
  input logic [7:0] dec_byte,
  input logic       dec_err
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_code == 10'd0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_code))); // R3

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_code inside {[10'd336:10'd351]})); // R8

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dec_code == out_code) |-> (!dec_err && dec_byte == $past(in_byte))); // R9

  AST_ERR_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> dec_byte == 8'd0); // R10

endmodule

bind marker_enc10 marker_enc10_chk u_chk (.*);

// File: tb/marker_enc10_tb.sv
module marker_enc10_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic [9:0] out_code;
  logic [9:0] dec_code = '0;
  logic [7:0] dec_byte;
  logic       dec_err;

  int checks = 0;
  int fails  = 0;
  int inv [1024];

  always #10 clk = ~clk;

  marker_enc10 u_dut (.*);

  typedef struct packed { logic [7:0] b; logic [9:0] c; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8'h10, 10'h20A},  // R4 marker case
    '{8'h00, 10'h140},  // R4
    '{8'h3F, 10'h17F},  // R4
    '{8'h40, 10'h0A0},  // R5
    '{8'h5A, 10'h0BA},  // R5
    '{8'h90, 10'h005},  // R6 marker case
    '{8'h9F, 10'h335},  // R6 marker case
    '{8'h80, 10'h050},  // R6
    '{8'hC8, 10'h0C5},  // R7 marker case
    '{8'hFF, 10'h3AF}   // R7
  };

  function automatic logic [9:0] model(input logic [7:0] x);
    logic [0:7] b;
    logic [0:9] o;
    b = x;
    if (b[0:1] == 2'b00 && b[2:3] == 2'b01)      o = {1'b1, b[5], b[4], b[6], 5'b00101, b[7]};
    else if (b[0:1] == 2'b00)                    o = {4'b0101, b[2:7]};
    else if (b[0:1] == 2'b01)                    o = {b[2], 4'b0101, b[3:7]};
    else if (b[0:1] == 2'b10 && b[2:3] == 2'b01) o = {b[4:5], 2'b00, b[6:7], 4'b0101};
    else if (b[0:1] == 2'b10)                    o = {b[2:3], 4'b0101, b[4:7]};
    else if (b[3:4] == 2'b01)                    o = {b[2], b[5], 2'b11, b[6:7], 4'b0101};
    else                                         o = {b[2:4], 4'b0101, b[5:7]};
    return o;
  endfunction

  function automatic string tag(input logic [7:0] x);
    case (x[7:6])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] x);
    in_byte  = x;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid, "R2 valid", out_valid, 1);
    chk(out_code == model(x), tag(x), out_code, model(x));
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!out_valid && out_code == 0, "R1", {out_valid, out_code}, 0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      in_byte  = VECS[i].b;
      in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid && out_code == VECS[i].c, tag(VECS[i].b), out_code, VECS[i].c);
    end

    for (int i = 0; i < 1024; i++) inv[i] = -1;
    for (int x = 0; x < 256; x++) begin
      logic [9:0] c;
      send(x[7:0]);
      c = model(x[7:0]);
      chk(!(out_code inside {[10'd336:10'd351]}), "R8 reserved", out_code, 0);
      chk(inv[c] < 0, "R8 unique", inv[c], -1);
      inv[c] = x;
    end

    // R3: idle cycle holds the code and drops valid
    send(8'h5A);
    in_valid = 1'b0;
    in_byte  = 8'hFF;
    @(negedge clk);
    chk(!out_valid, "R3 valid", out_valid, 0);
    chk(out_code == 10'h0BA, "R3 hold", out_code, 10'h0BA);
    @(negedge clk);
    chk(out_code == 10'h0BA, "R3 hold2", out_code, 10'h0BA);

    // R1: reset mid-run
    send(8'hC8);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && out_code == 0, "R1 mid", {out_valid, out_code}, 0);
    rst = 1'b0;
    in_valid = 1'b0;

    for (int w = 0; w < 1024; w++) begin
      dec_code = w[9:0];
      #1;
      if (inv[w] >= 0)
        chk(!dec_err && dec_byte == inv[w][7:0], "R9", {dec_err, dec_byte}, inv[w]);
      else
        chk(dec_err && dec_byte == 0, "R10", {dec_err, dec_byte}, 9'h100);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule